// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A controller hands it a 10-bit starting column with a one-cycle start pulse. From the next cycle on, the block presents one column address per clock with a valid strobe. On the final beat of a fixed-length burst it also raises a last-beat flag. A stop pulse ends the sequence early. A new start at any time abandons the running burst and begins a fresh one.

The burst length and the beat ordering come from a small configuration word, written the way a mode register is written. The word is taken only while the generator is idle. The supported lengths are 1, 2, 4 and 8 beats, plus an open-ended full-page mode. Full-page mode walks through the whole 1024-column row and wraps around until a stop or a new start arrives. For fixed lengths the beats can follow either sequential or interleaved order inside the aligned block that holds the starting column.

The controller is a three-state machine:
- IDLE: no output.
- BURST: a fixed-length burst is running.
- PAGE: a full-page burst is running.

Its transitions are:
- launch: IDLE to BURST or PAGE on start.
- advance: the next beat in the same state.
- finish: BURST to IDLE after the last beat.
- halt: BURST or PAGE to IDLE on stop.
- relaunch: start while busy, which re-enters BURST or PAGE at beat 0.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid` and `col_last` are low, and the configuration selects a burst length of 1 in sequential order.
- R2: `cfg_word[2:0]` selects the burst length: code 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4, 5 and 6 behave as length 1. `cfg_word[3]` selects the ordering: 0 is sequential and 1 is interleaved. The word is stored at a clock edge where `cfg_we` is high and the generator is idle.
- R3: A start sampled at a clock edge makes `col_valid` high in the following cycle, with `col_out` equal to the sampled `start_col` as beat 0.
- R4: In sequential order with length BL, beat i carries the upper column bits of the start column unchanged. Its low log2(BL) bits equal the start column's low bits plus i, modulo BL.
- R5: In interleaved order with length BL, beat i equals the start column with its low log2(BL) bits XORed with i.
- R6: In full-page mode, beat i is (start column + i) modulo 1024, so column 1023 is followed by 0. The ordering bit is ignored, and the burst runs until a stop or a start.
- R7: `col_last` is high exactly on beat BL-1 of a fixed-length burst and never in full-page mode. `col_valid` is low in the cycle after the last beat unless a start was sampled at that edge.
- R8: A stop sampled at an edge during a burst makes `col_valid` low from the next cycle. A stop while idle has no effect.
- R9: A start sampled during a running burst abandons it, and beat 0 of the new burst appears in the next cycle. Start takes priority over a stop sampled at the same edge.
- R10: A configuration write while a burst is running is ignored: the running burst and later bursts keep the earlier length and ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, honoured only while idle |
| cfg_word | input | 4 | Configuration word: [2:0] length code, [3] ordering |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 10 | Starting column of the burst |
| stop | input | 1 | End the running burst |
| col_out | output | 10 | Column address of the current beat |
| col_valid | output | 1 | `col_out` carries a beat this cycle |
| col_last | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
Every result of this block is due one clock after the edge that samples its cause. Beat 0 follows the start edge by one cycle, and each further beat follows the previous one by one cycle. The drop of `col_valid` after a stop or after the last beat also lands one cycle after the sampling edge. The bench pushes the full expected beat list, including the last-beat flags, into a queue before it raises start. A monitor samples the outputs at every falling edge and pops one item for each valid cycle, so any early, late, extra or missing beat shows up as a mismatch or as a non-empty queue. A stop or restart is driven in the falling edge where the beat that should be final is showing. The bench therefore truncates the expected list at exactly that beat.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BURST = 2'd1,
        S_PAGE  = 2'd2
    } bcg_state_e;

    localparam int CFG_W       = 4;
    localparam int LEN_CODE_W  = 3;
    localparam int ORDER_BIT   = 3;
    localparam int MAX_POW     = 3;
    localparam logic [LEN_CODE_W-1:0] PAGE_CODE = 3'd7;
endpackage

// File: rtl/bcg_cfg_decode.sv
module bcg_cfg_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [CFG_W-1:0] cfg,
    output logic [COL_W-1:0] mask,
    output logic             page,
    output logic             intl
);
    logic [LEN_CODE_W-1:0] code;

    always_comb begin
        code = cfg[LEN_CODE_W-1:0];
        page = (code == PAGE_CODE);
        intl = cfg[ORDER_BIT] && !page;
        mask = '0;
        if (page) begin
            mask = '1;
        end else if (int'(code) <= MAX_POW) begin
            mask = COL_W'((1 << code) - 1);
        end
    end
endmodule

// File: rtl/bcg_col_calc.sv
module bcg_col_calc #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             intl,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;

    always_comb begin
        seq_col = (base_col & ~mask) | ((base_col + beat) & mask);
        ilv_col = base_col ^ (beat & mask);
        col     = intl ? ilv_col : seq_col;
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_word,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last
);
    bcg_state_e       state_q, state_d;
    logic [COL_W-1:0] beat_q, beat_d, beat_nx;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] col_q, col_d, col_nx;
    logic [CFG_W-1:0] cfg_q, cfg_eff;
    logic             cfg_take;

    logic [COL_W-1:0] run_mask, new_mask;
    logic             run_page, new_page;
    logic             run_intl, new_intl;

    assign cfg_take = cfg_we && (state_q == S_IDLE);
    assign cfg_eff  = cfg_take ? cfg_word : cfg_q;
    assign beat_nx  = beat_q + 1'b1;

    bcg_cfg_decode #(.COL_W(COL_W)) u_dec_run (
        .cfg (cfg_q),
        .mask(run_mask),
        .page(run_page),
        .intl(run_intl)
    );

    bcg_cfg_decode #(.COL_W(COL_W)) u_dec_new (
        .cfg (cfg_eff),
        .mask(new_mask),
        .page(new_page),
        .intl(new_intl)
    );

    bcg_col_calc #(.COL_W(COL_W)) u_calc (
        .base_col(base_q),
        .beat    (beat_nx),
        .mask    (run_mask),
        .intl    (run_intl),
        .col     (col_nx)
    );

    // next-state and datapath selection
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        base_d  = base_q;
        col_d   = col_q;
        if (start) begin
            state_d = new_page ? S_PAGE : S_BURST;
            beat_d  = '0;
            base_d  = start_col;
            col_d   = start_col;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    state_d = S_IDLE;
                end
                S_BURST: begin
                    if (stop || (beat_q == run_mask)) begin
                        state_d = S_IDLE;
                    end else begin
                        beat_d = beat_nx;
                        col_d  = col_nx;
                    end
                end
                S_PAGE: begin
                    if (stop) begin
                        state_d = S_IDLE;
                    end else begin
                        beat_d = beat_nx;
                        col_d  = col_nx;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
            col_q   <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            base_q  <= base_d;
            col_q   <= col_d;
            if (cfg_take) begin
                cfg_q <= cfg_word;
            end
        end
    end

    // outputs
    always_comb begin
        col_out   = col_q;
        col_valid = (state_q != S_IDLE);
        col_last  = (state_q == S_BURST) && (beat_q == run_mask);
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_out == $past(start_col)));                      // R3
    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && stop && col_valid) |=> col_valid);                                 // R9
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start) |=> !col_valid);                                        // R7
    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);                                                     // R7
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !col_valid);                                            // R8
    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PAGE && col_out == '1 && !start && !stop) |=> col_out == '0);  // R6
    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BURST && !col_last && !start && !stop)
        |=> (((col_out ^ $past(col_out)) & ~run_mask) == '0));                       // R4
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(cfg_q));                                     // R10
endmodule

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_word = '0;
    logic       start = 1'b0;
    logic [9:0] start_col = '0;
    logic       stop = 1'b0;
    logic [9:0] col_out;
    logic       col_valid;
    logic       col_last;

    int    errors = 0;
    int    checks = 0;
    int    expq[$];
    string cur_req = "R1";
    bit    finished = 1'b0;

    always #4 clk = ~clk;

    burst_col_gen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_word (cfg_word),
        .start    (start),
        .start_col(start_col),
        .stop     (stop),
        .col_out  (col_out),
        .col_valid(col_valid),
        .col_last (col_last)
    );

    function automatic int exp_item(int s, int i, int code, bit il);
        int bl, base, c, last;
        if (code == 7) begin
            c = (s + i) % 1024;
            last = 0;
        end else begin
            bl   = (code <= 3) ? (1 << code) : 1;
            base = s - (s % bl);
            c    = il ? base + ((s % bl) ^ i) : base + (((s % bl) + i) % bl);
            last = (i == bl - 1) ? 1 : 0;
        end
        return last * 1024 + c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_beats(input int s, input int n, input int code, input bit il);
        for (int i = 0; i < n; i++) expq.push_back(exp_item(s, i, code, il));
    endtask

    task automatic set_cfg(input logic [3:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start(input int s);
        @(negedge clk);
        start = 1'b1; start_col = 10'(s);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain(input int n);
        repeat (n) @(negedge clk);
        check(expq.size() == 0, cur_req, expq.size(), 0);
    endtask

    // monitor: compare each valid beat against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && col_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, cur_req, int'(col_out), -1);
                end else begin
                    int e;
                    e = expq.pop_front();
                    check({21'd0, col_last, col_out} == e, cur_req,
                          int'({col_last, col_out}), e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check(col_valid == 1'b0, "R1", col_valid, 0);
        check(col_last == 1'b0, "R1", col_last, 0);
        // R1: default length 1
        push_beats(100, 1, 0, 0);
        pulse_start(100);
        drain(4);

        // R4: sequential length 4, wrap inside aligned block
        cur_req = "R4";
        set_cfg(4'd2);
        push_beats(1022, 4, 2, 0);
        pulse_start(1022);
        drain(6);
        // R4: sequential length 8 from mid-block
        set_cfg(4'd3);
        push_beats(13, 8, 3, 0);
        pulse_start(13);
        drain(10);

        // R5: interleaved length 8 and 2
        cur_req = "R5";
        set_cfg(4'd11);
        push_beats(5, 8, 3, 1);
        pulse_start(5);
        drain(10);
        set_cfg(4'd9);
        push_beats(7, 2, 1, 1);
        pulse_start(7);
        drain(4);

        // R2: reserved length code behaves as length 1
        cur_req = "R2";
        set_cfg(4'd5);
        push_beats(77, 1, 5, 0);
        pulse_start(77);
        drain(4);

        // R10: config write during burst ignored
        cur_req = "R10";
        set_cfg(4'd2);
        push_beats(0, 4, 2, 0);
        pulse_start(0);
        cfg_we = 1'b1; cfg_word = 4'd3;
        @(negedge clk);
        cfg_we = 1'b0;
        drain(6);
        push_beats(40, 4, 2, 0);
        pulse_start(40);
        drain(6);

        // R8: stop after 3 beats of length 8
        cur_req = "R8";
        set_cfg(4'd3);
        push_beats(16, 3, 3, 0);
        pulse_start(16);
        repeat (2) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        drain(6);
        // R8: stop while idle has no effect
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        repeat (2) @(negedge clk);
        check(col_valid == 1'b0, "R8", col_valid, 0);
        push_beats(24, 8, 3, 0);
        pulse_start(24);
        drain(10);

        // R9: restart after 2 beats, with a simultaneous stop
        cur_req = "R9";
        push_beats(200, 2, 3, 0);
        push_beats(300, 8, 3, 0);
        pulse_start(200);
        @(negedge clk);
        start = 1'b1; start_col = 10'd300; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        drain(10);

        // R6: full page, ordering bit ignored, wraps 1023 -> 0
        cur_req = "R6";
        set_cfg(4'd15);
        push_beats(1020, 1030, 7, 1);
        pulse_start(1020);
        repeat (1029) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        drain(5);
        check(col_last == 1'b0 && col_valid == 1'b0, "R7", {col_last, col_valid}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule